// File: doc/BRIEF.md
# Configuration Header Register File (identity, command, status)

This block holds the first two dwords of a type-0 PCI configuration header for a function that is both a target and a bus master. The first dword is a fixed pair of identity codes: a vendor code in the low half and a device code in the high half. The second dword holds a command word in its low half and a status word in its high half.

Software reaches the block through a plain configuration access port. The port carries a dword index, four byte enables, 32-bit write data, a write strobe and a read strobe. Read data is registered and appears one cycle after the read strobe is sampled.

Most command bits are wired to 0 or 1. Three command bits are writable, and each drives an enable output to the bus logic around the block. Five status bits record bus error events: an event pulse sets the bit, and writing 1 to the bit clears it. The remaining status bits are constants, and among them is a medium device-select timing code. Decoding of the bus protocol is done elsewhere.

Top module: `cfg_hdr_top`

## Requirements
- R1: After reset, a read of index 0 returns 32'h0001_1078. A read of index 1 returns 32'h0280_0007. Out of reset, serrEnable and parityRespEnable are 0 and busMasterEnable is 1.
- R2: Index 0 reads as {DEVICE_ID, VENDOR_ID}, which is 16'h0001 in bits 31:16 and 16'h1078 in bits 15:0. Writes to index 0, with any byte enables, change nothing.
- R3: In the command word (bits 15:0 of index 1), bits 15:9, 7, 5, 4 and 3 always read 0, and bits 1 and 0 always read 1, whatever is written.
- R4: Command bit 2 (bus master enable) and bit 6 (parity response) load from write data when byte enable 0 is set. Command bit 8 (system error enable) loads when byte enable 1 is set. These bits drive busMasterEnable, parityRespEnable and serrEnable directly.
- R5: A byte whose enable is clear is left unchanged by a write. A cycle with no write strobe changes no writable bit.
- R6: In the status word (bits 31:16 of index 1), bits 10:9 always read 01, which is the medium device-select timing code (00 fast, 10 slow, 11 reserved). Status bit 7 always reads 1. Status bits 8 and 6:0 always read 0.
- R7: The following events set status bits, and each bit stays set afterwards: evtParityErr sets bit 15, evtSerrDriven sets bit 14, evtMasterAbort sets bit 13, evtTargetAbortRcvd sets bit 12 and evtTargetAbortSent sets bit 11. In the read dword these are bits 31:27.
- R8: A write to index 1 with byte enable 3 set clears each of status bits 15:11 whose write-data bit (31:27) is 1. A 0 in the write data leaves the bit unchanged.
- R9: When a set event and a write-1 clear hit the same status bit in the same cycle, the bit ends up 1.
- R10: cfgRdData shows the register value one cycle after cfgRd is sampled high. If a write happens in the same cycle, the value shown is the one from before that write. Unmapped indices (2 and above) read 0, and cfgRdData is 0 in any cycle after one without cfgRd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgIndex | input | IDX_W | Dword index of the access |
| cfgByteEn | input | 4 | Byte enables for writes |
| cfgWrData | input | 32 | Write data |
| cfgWr | input | 1 | Write strobe |
| cfgRd | input | 1 | Read strobe |
| cfgRdData | output | 32 | Registered read data |
| evtParityErr | input | 1 | Parity error detected pulse |
| evtSerrDriven | input | 1 | System error line driven pulse |
| evtMasterAbort | input | 1 | Master abort received pulse |
| evtTargetAbortRcvd | input | 1 | Target abort received pulse |
| evtTargetAbortSent | input | 1 | Target abort signalled pulse |
| serrEnable | output | 1 | Output enable for the system error driver |
| parityRespEnable | output | 1 | Parity checking enabled |
| busMasterEnable | output | 1 | Master cycles allowed |

## Verification
The bench builds the block with its default parameters. IDX_W is 6, so the random index choice can reach unmapped indices as high as 63. The identity codes stay at 16'h1078 and 16'h0001, so the fixed read values can be compared with literal constants. Random byte-enable masks, write data and sparse event pulses cover every mix of partial writes, write-1 clears and event sets. Directed cycles force the set-versus-clear collision and the read-during-write case.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;

  // Strobes from the decode control to the register datapath
  typedef struct packed {
    logic cmdLoWr;    // write to command byte 0
    logic cmdHiWr;    // write to command byte 1
    logic statHiWr;   // write to status byte 1 (error bits)
    logic rdId;       // read of the identity dword
    logic rdCmdStat;  // read of the command/status dword
  } cfgStrobes_t;

  localparam int ERR_BITS = 5;
  localparam logic [1:0] DEVSEL_MEDIUM = 2'b01;
  localparam int ID_INDEX = 0;
  localparam int CMDSTAT_INDEX = 1;

endpackage

// File: rtl/cfg_hdr_ctrl.sv
module cfg_hdr_ctrl
  import cfg_hdr_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [IDX_W-1:0] cfgIndex,
  input  logic [3:0]       cfgByteEn,
  input  logic             cfgWr,
  input  logic             cfgRd,
  output cfgStrobes_t      strobes
);

  localparam logic [IDX_W-1:0] IDX_ID  = IDX_W'(ID_INDEX);
  localparam logic [IDX_W-1:0] IDX_CMD = IDX_W'(CMDSTAT_INDEX);

  logic hitId;
  logic hitCmd;
  logic unusedBe;

  assign hitId    = (cfgIndex == IDX_ID);
  assign hitCmd   = (cfgIndex == IDX_CMD);
  assign unusedBe = cfgByteEn[2]; // status byte 0 holds constants only

  always_comb begin
    strobes           = '0;
    strobes.cmdLoWr   = cfgWr && hitCmd && cfgByteEn[0];
    strobes.cmdHiWr   = cfgWr && hitCmd && cfgByteEn[1];
    strobes.statHiWr  = cfgWr && hitCmd && cfgByteEn[3];
    strobes.rdId      = cfgRd && hitId;
    strobes.rdCmdStat = cfgRd && hitCmd;
  end

  // R5: no write strobe, no register write
  p_no_wr_idle_r5: assert property (@(posedge clk) disable iff (!rstN)
    !cfgWr |-> !(strobes.cmdLoWr || strobes.cmdHiWr || strobes.statHiWr));

  // R5: a cleared byte enable blocks the error-bit write
  p_be_gate_r5: assert property (@(posedge clk) disable iff (!rstN)
    !cfgByteEn[3] |-> !strobes.statHiWr);

  // R10: the two read targets never collide
  p_rd_excl_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.rdId && strobes.rdCmdStat));

endmodule

// File: rtl/cfg_hdr_dpath.sv
module cfg_hdr_dpath
  import cfg_hdr_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID = 16'h1078,
  parameter logic [15:0] DEVICE_ID = 16'h0001
) (
  input  logic        clk,
  input  logic        rstN,
  input  cfgStrobes_t strobes,
  input  logic [31:0] wrData,
  input  logic [ERR_BITS-1:0] errSet,  // {15,14,13,12,11}
  output logic [31:0] rdData,
  output logic        serrEnable,
  output logic        parityRespEnable,
  output logic        busMasterEnable
);

  localparam int ERR_LSB = 27; // status bit 11 sits at dword bit 27

  logic                serrEnR;
  logic                perrRespR;
  logic                bmEnR;
  logic [ERR_BITS-1:0] errR;
  logic [ERR_BITS-1:0] errClr;
  logic [15:0]         cmdWord;
  logic [15:0]         statWord;
  logic [31:0]         rdDataR;
  logic                unusedWr;

  assign unusedWr = ^{wrData[26:9], wrData[7], wrData[5:3], wrData[1:0]};

  // Writable command bits
  always_ff @(posedge clk) begin
    if (!rstN) begin
      serrEnR   <= 1'b0;
      perrRespR <= 1'b0;
      bmEnR     <= 1'b1;
    end else begin
      if (strobes.cmdLoWr) begin
        bmEnR     <= wrData[2];
        perrRespR <= wrData[6];
      end
      if (strobes.cmdHiWr) begin
        serrEnR <= wrData[8];
      end
    end
  end

  assign errClr = strobes.statHiWr ? wrData[ERR_LSB +: ERR_BITS] : '0;

  // Sticky error bits: event set beats write-1 clear
  for (genvar gi = 0; gi < ERR_BITS; gi++) begin : g_err
    always_ff @(posedge clk) begin
      if (!rstN)            errR[gi] <= 1'b0;
      else if (errSet[gi])  errR[gi] <= 1'b1;
      else if (errClr[gi])  errR[gi] <= 1'b0;
    end

    // R9: a set event always leaves the bit high
    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rstN)
      errSet[gi] |=> errR[gi]);

    // R8: a lone write-1 clears the bit
    p_w1c_r8: assert property (@(posedge clk) disable iff (!rstN)
      (errClr[gi] && !errSet[gi]) |=> !errR[gi]);

    // R7: without clear the bit never falls
    p_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
      !errClr[gi] |=> !$fell(errR[gi]));
  end

  assign cmdWord  = {6'b0, 1'b0, serrEnR, 1'b0, perrRespR, 3'b000, bmEnR, 2'b11};
  assign statWord = {errR, DEVSEL_MEDIUM, 1'b0, 1'b1, 7'b0};

  always_ff @(posedge clk) begin
    if (!rstN)                  rdDataR <= '0;
    else if (strobes.rdId)      rdDataR <= {DEVICE_ID, VENDOR_ID};
    else if (strobes.rdCmdStat) rdDataR <= {statWord, cmdWord};
    else                        rdDataR <= '0;
  end

  assign rdData           = rdDataR;
  assign serrEnable       = serrEnR;
  assign parityRespEnable = perrRespR;
  assign busMasterEnable  = bmEnR;

  // R5: enables hold when their byte is not written
  p_bm_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.cmdLoWr |=> $stable(busMasterEnable) && $stable(parityRespEnable));
  p_serr_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.cmdHiWr |=> $stable(serrEnable));

  // R3 / R6: constant fields in a command/status read
  p_const_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.rdCmdStat |=> (rdData[26:25] == 2'b01) && rdData[23] && (rdData[1:0] == 2'b11)
                          && (rdData[15:9] == 7'b0));

  // R2: identity read returns the fixed codes
  p_id_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.rdId |=> rdData == {DEVICE_ID, VENDOR_ID});

endmodule

// File: rtl/cfg_hdr_top.sv
module cfg_hdr_top
  import cfg_hdr_pkg::*;
#(
  parameter int          IDX_W     = 6,
  parameter logic [15:0] VENDOR_ID = 16'h1078,
  parameter logic [15:0] DEVICE_ID = 16'h0001
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [IDX_W-1:0] cfgIndex,
  input  logic [3:0]       cfgByteEn,
  input  logic [31:0]      cfgWrData,
  input  logic             cfgWr,
  input  logic             cfgRd,
  output logic [31:0]      cfgRdData,
  input  logic             evtParityErr,
  input  logic             evtSerrDriven,
  input  logic             evtMasterAbort,
  input  logic             evtTargetAbortRcvd,
  input  logic             evtTargetAbortSent,
  output logic             serrEnable,
  output logic             parityRespEnable,
  output logic             busMasterEnable
);

  cfgStrobes_t         strobes;
  logic [ERR_BITS-1:0] errSet;

  assign errSet = {evtParityErr, evtSerrDriven, evtMasterAbort,
                   evtTargetAbortRcvd, evtTargetAbortSent};

  cfg_hdr_ctrl #(.IDX_W(IDX_W)) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cfgIndex  (cfgIndex),
    .cfgByteEn (cfgByteEn),
    .cfgWr     (cfgWr),
    .cfgRd     (cfgRd),
    .strobes   (strobes)
  );

  cfg_hdr_dpath #(.VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID)) i_dpath (
    .clk              (clk),
    .rstN             (rstN),
    .strobes          (strobes),
    .wrData           (cfgWrData),
    .errSet           (errSet),
    .rdData           (cfgRdData),
    .serrEnable       (serrEnable),
    .parityRespEnable (parityRespEnable),
    .busMasterEnable  (busMasterEnable)
  );

endmodule

// File: tb/test_cfg_hdr_top.sv
`timescale 1ns/1ps
module test_cfg_hdr_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [5:0]  cfgIndex = '0;
  logic [3:0]  cfgByteEn = '0;
  logic [31:0] cfgWrData = '0;
  logic        cfgWr = 1'b0;
  logic        cfgRd = 1'b0;
  logic [31:0] cfgRdData;
  logic [4:0]  evts = '0;
  logic        serrEnable, parityRespEnable, busMasterEnable;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // model state
  logic       mSe, mPe, mBm;
  logic [4:0] mErr;

  always #2.5 clk = ~clk;

  cfg_hdr_top i_cfg_hdr_top (
    .clk(clk), .rstN(rstN), .cfgIndex(cfgIndex), .cfgByteEn(cfgByteEn),
    .cfgWrData(cfgWrData), .cfgWr(cfgWr), .cfgRd(cfgRd), .cfgRdData(cfgRdData),
    .evtParityErr(evts[4]), .evtSerrDriven(evts[3]), .evtMasterAbort(evts[2]),
    .evtTargetAbortRcvd(evts[1]), .evtTargetAbortSent(evts[0]),
    .serrEnable(serrEnable), .parityRespEnable(parityRespEnable),
    .busMasterEnable(busMasterEnable)
  );

  function automatic logic [15:0] expCmd();
    return {7'b0, mSe, 1'b0, mPe, 3'b000, mBm, 2'b11};
  endfunction

  function automatic logic [15:0] expStat();
    return {mErr, 2'b01, 1'b0, 1'b1, 7'b0};
  endfunction

  function automatic logic [31:0] expRead(input logic [5:0] idx);
    if (idx == 6'd0) return 32'h0001_1078;
    if (idx == 6'd1) return {expStat(), expCmd()};
    return 32'h0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One access cycle: drive at negedge, check results at the next negedge
  task automatic doCycle(input string req, input logic [5:0] idx, input logic [3:0] be,
                         input logic wr, input logic rd, input logic [31:0] d,
                         input logic [4:0] ev);
    logic [31:0] expRd;
    cfgIndex = idx; cfgByteEn = be; cfgWr = wr; cfgRd = rd; cfgWrData = d; evts = ev;
    @(posedge clk);
    expRd = rd ? expRead(idx) : 32'h0;
    if (wr && idx == 6'd1) begin
      if (be[0]) begin mBm = d[2]; mPe = d[6]; end
      if (be[1]) mSe = d[8];
      if (be[3]) mErr = mErr & ~d[31:27];
    end
    mErr = mErr | ev;
    @(negedge clk);
    chk({req, " R10 rdData"}, cfgRdData, expRd);
    chk({req, " R4 enables"}, {29'b0, serrEnable, parityRespEnable, busMasterEnable},
        {29'b0, mSe, mPe, mBm});
  endtask

  task automatic idle();
    cfgWr = 1'b0; cfgRd = 1'b0; evts = '0;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog all requirements actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    mSe = 1'b0; mPe = 1'b0; mBm = 1'b1; mErr = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    chk("R1 enables after reset", {29'b0, serrEnable, parityRespEnable, busMasterEnable}, 32'h1);
    doCycle("R1 id", 6'd0, 4'h0, 1'b0, 1'b1, 32'h0, 5'h0);
    chk("R1 id literal", cfgRdData, 32'h0001_1078);
    doCycle("R1 cmdstat", 6'd1, 4'h0, 1'b0, 1'b1, 32'h0, 5'h0);
    chk("R1 cmdstat literal", cfgRdData, 32'h0280_0007);

    // R2: identity writes ignored
    doCycle("R2 write", 6'd0, 4'hF, 1'b1, 1'b0, 32'hFFFF_FFFF, 5'h0);
    doCycle("R2 read", 6'd0, 4'h0, 1'b0, 1'b1, 32'h0, 5'h0);
    chk("R2 id unchanged", cfgRdData, 32'h0001_1078);

    // R3 / R4: all ones into command bytes
    doCycle("R4 write", 6'd1, 4'h3, 1'b1, 1'b0, 32'hFFFF_FFFF, 5'h0);
    doCycle("R3 read", 6'd1, 4'h0, 1'b0, 1'b1, 32'h0, 5'h0);
    chk("R3 cmd hardwired", {16'h0, cfgRdData[15:0]}, 32'h0000_0147);
    chk("R6 status constants", {16'h0, cfgRdData[31:16]}, 32'h0000_0280);

    // R5: only byte 0 written, serr enable holds
    doCycle("R5 write", 6'd1, 4'h1, 1'b1, 1'b0, 32'h0, 5'h0);
    chk("R5 serr kept", {31'b0, serrEnable}, 32'h1);
    chk("R5 bm cleared", {31'b0, busMasterEnable}, 32'h0);

    // R7: every event sets its bit
    doCycle("R7 events", 6'd1, 4'h0, 1'b0, 1'b0, 32'h0, 5'h1F);
    doCycle("R7 read", 6'd1, 4'h0, 1'b0, 1'b1, 32'h0, 5'h0);
    chk("R7 status all set", {16'h0, cfgRdData[31:16]}, 32'h0000_FA80);

    // R8: zero write keeps, one write clears bit 13
    doCycle("R8 zero", 6'd1, 4'h8, 1'b1, 1'b0, 32'h0, 5'h0);
    doCycle("R8 one", 6'd1, 4'h8, 1'b1, 1'b0, 32'h2000_0000, 5'h0);
    doCycle("R8 read", 6'd1, 4'h0, 1'b0, 1'b1, 32'h0, 5'h0);
    chk("R8 bit13 cleared", {16'h0, cfgRdData[31:16]}, 32'h0000_DA80);

    // R9: set and clear together on bit 13
    doCycle("R9 clash", 6'd1, 4'h8, 1'b1, 1'b0, 32'hF800_0000, 5'h04);
    doCycle("R9 read", 6'd1, 4'h0, 1'b0, 1'b1, 32'h0, 5'h0);
    chk("R9 set wins", {16'h0, cfgRdData[31:16]}, 32'h0000_2280);

    // R10: read during write shows old value; unmapped index reads 0
    doCycle("R10 rdwr", 6'd1, 4'h1, 1'b1, 1'b1, 32'h0000_0004, 5'h0);
    chk("R10 old value", cfgRdData, 32'h2280_0103);
    doCycle("R10 unmapped", 6'd63, 4'hF, 1'b1, 1'b1, 32'hFFFF_FFFF, 5'h0);
    chk("R10 unmapped zero", cfgRdData, 32'h0);

    // Random traffic
    for (int n = 0; n < 3000; n++) begin
      logic [5:0] idx;
      logic [4:0] ev;
      int sel;
      sel = $urandom_range(0, 9);
      idx = (sel < 3) ? 6'd0 : (sel < 8) ? 6'd1 : 6'($urandom_range(2, 63));
      ev = '0;
      for (int b = 0; b < 5; b++) if ($urandom_range(0, 15) == 0) ev[b] = 1'b1;
      doCycle("R5 R7 R8 R9 random", idx, 4'($urandom_range(0, 15)),
              1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), $urandom, ev);
    end
    idle();

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule